// File: doc/BRIEF.md
# Scalar Half-Precision Multiply-Subtract Operand and Mask Stage

This stage sits around a three-input half-precision fused multiply-subtract core that computes `±A*B − C`. Each cycle it can accept one operation: a 128-bit destination register value, a second and a third 128-bit source, an operand-order form, a negate bit, masking controls and two candidate rounding modes. It steers the low 16-bit element of each register to the core's A, B and C inputs according to the form. It forwards the negate bit, and it picks the rounding mode from either the instruction's embedded field or the control-register field.

The core result and its exception flags come back in the same cycle. On the next clock edge the stage presents the complete destination value. Only the low element may change, under merge or zero masking. Bits 127:16 keep their old values, and every bit from 128 up to the parameterised maximum vector length is cleared. The exception flags are passed on only when the element was actually computed.

Top module: `fms_lane_stage`

## Requirements
- R1: With form code 2'b00, the core inputs are A = dest[15:0], B = src3[15:0] and C = src2[15:0].
- R2: With form code 2'b01, the core inputs are A = src2[15:0], B = dest[15:0] and C = src3[15:0].
- R3: With form code 2'b10, the core inputs are A = src2[15:0], B = src3[15:0] and C = dest[15:0]. Code 2'b11 behaves the same as 2'b10.
- R4: The core negate input equals the negate request.
- R5: When embedded rounding is enabled and the third source is a register, the core rounding mode equals the embedded mode.
- R6: In every other case, the core rounding mode equals the control-register mode.
- R7: When masking is off, or the mask bit is 1, result bits [15:0] equal the core result.
- R8: When masking is on, the mask bit is 0 and zeroing is selected, result bits [15:0] are 0.
- R9: When masking is on, the mask bit is 0 and zeroing is not selected, result bits [15:0] equal dest[15:0].
- R10: Result bits [127:16] equal dest[127:16], and result bits [MAXVL-1:128] are 0.
- R11: The output flags equal the core flags when the element is computed (R7 case) and are 0 otherwise.
- R12: Results appear one clock after an accepted operation, with the valid output high for exactly that cycle. Reset clears valid, result and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| formSel | input | 2 | Operand order: 00 = 132, 01 = 213, 10/11 = 231 |
| negate | input | 1 | Negate the product |
| maskOn | input | 1 | A write mask is in use |
| maskBit | input | 1 | Mask bit 0 |
| zeroMode | input | 1 | 1 = zero a masked-off element, 0 = merge |
| embRoundEn | input | 1 | Embedded rounding requested |
| embRound | input | 2 | Embedded rounding mode |
| ctlRound | input | 2 | Control-register rounding mode |
| src3IsReg | input | 1 | Third source is a register |
| destIn | input | 128 | Old destination register value |
| src2In | input | 128 | Second source register |
| src3In | input | 128 | Third source register |
| coreA | output | 16 | Core multiplicand |
| coreB | output | 16 | Core multiplier |
| coreC | output | 16 | Core subtrahend |
| coreNeg | output | 1 | Core product negate |
| coreRound | output | 2 | Core rounding mode |
| coreResult | input | 16 | Core result |
| coreFlags | input | 5 | Core exception flags |
| outValid | output | 1 | Result valid |
| destOut | output | MAXVL | Full destination value |
| flagsOut | output | 5 | Forwarded exception flags |

## Verification
The bench builds the stage with the default 512-bit maximum vector length. At that width there are 384 cleared upper bits, so a failure to clear any bit above 127 is visible. The bench stands in for the core with a scrambling function that is not symmetric in A, B and C. Because of that, any operand swap, a dropped negate or a wrong rounding choice changes the result. It runs all four form codes, both negate values, all eight mask, mask-bit and zeroing combinations, and all four combinations of embedded-enable and register-source, on random register contents.

// File: rtl/fms_pkg.sv
package fms_pkg;
  localparam int LANE_W = 16;
  localparam int REG_W  = 128;
  localparam int FLAG_W = 5;
  localparam int RM_W   = 2;

  typedef enum logic [1:0] {
    FORM_132 = 2'b00,
    FORM_213 = 2'b01,
    FORM_231 = 2'b10,
    FORM_ALT = 2'b11
  } formT;

  typedef enum logic [1:0] {
    SRC_DEST = 2'd0,
    SRC_TWO  = 2'd1,
    SRC_THREE = 2'd2
  } laneSrcT;

  typedef enum logic [1:0] {
    LOW_RESULT = 2'd0,
    LOW_ZERO   = 2'd1,
    LOW_KEEP   = 2'd2
  } lowSelT;

  typedef struct packed {
    laneSrcT selA;
    laneSrcT selB;
    laneSrcT selC;
    lowSelT  lowSel;
    logic    flagEn;
  } strobeT;
endpackage

// File: rtl/fms_ctrl.sv
module fms_ctrl
  import fms_pkg::*;
(
  input  logic [1:0]      formSel,
  input  logic            maskOn,
  input  logic            maskBit,
  input  logic            zeroMode,
  input  logic            embRoundEn,
  input  logic [RM_W-1:0] embRound,
  input  logic [RM_W-1:0] ctlRound,
  input  logic            src3IsReg,
  output strobeT          strobe,
  output logic [RM_W-1:0] roundMode
);
  logic doWrite;

  always_comb begin
    unique case (formT'(formSel))
      FORM_132: begin
        strobe.selA = SRC_DEST; strobe.selB = SRC_THREE; strobe.selC = SRC_TWO;
      end
      FORM_213: begin
        strobe.selA = SRC_TWO; strobe.selB = SRC_DEST; strobe.selC = SRC_THREE;
      end
      default: begin
        strobe.selA = SRC_TWO; strobe.selB = SRC_THREE; strobe.selC = SRC_DEST;
      end
    endcase
    doWrite = !maskOn || maskBit;
    if (doWrite)       strobe.lowSel = LOW_RESULT;
    else if (zeroMode) strobe.lowSel = LOW_ZERO;
    else               strobe.lowSel = LOW_KEEP;
    strobe.flagEn = doWrite;
    roundMode = (embRoundEn && src3IsReg) ? embRound : ctlRound;
  end
endmodule

// File: rtl/fms_datapath.sv
module fms_datapath
  import fms_pkg::*;
#(
  parameter int MAXVL = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  strobeT            strobe,
  input  logic [REG_W-1:0]  destIn,
  input  logic [REG_W-1:0]  src2In,
  input  logic [REG_W-1:0]  src3In,
  output logic [LANE_W-1:0] coreA,
  output logic [LANE_W-1:0] coreB,
  output logic [LANE_W-1:0] coreC,
  input  logic [LANE_W-1:0] coreResult,
  input  logic [FLAG_W-1:0] coreFlags,
  output logic              outValid,
  output logic [MAXVL-1:0]  destOut,
  output logic [FLAG_W-1:0] flagsOut
);
  localparam int NUM_OPS = 3;

  laneSrcT           opSel  [NUM_OPS];
  logic [LANE_W-1:0] opLane [NUM_OPS];
  logic [LANE_W-1:0] lowNext;
  logic [MAXVL-1:0]  destNext;
  logic              unusedHigh;

  assign opSel[0] = strobe.selA;
  assign opSel[1] = strobe.selB;
  assign opSel[2] = strobe.selC;

  for (genvar g = 0; g < NUM_OPS; g++) begin : gOperand
    always_comb begin
      unique case (opSel[g])
        SRC_DEST:  opLane[g] = destIn[LANE_W-1:0];
        SRC_TWO:   opLane[g] = src2In[LANE_W-1:0];
        default:   opLane[g] = src3In[LANE_W-1:0];
      endcase
    end
  end

  assign coreA = opLane[0];
  assign coreB = opLane[1];
  assign coreC = opLane[2];
  assign unusedHigh = ^{src2In[REG_W-1:LANE_W], src3In[REG_W-1:LANE_W]};

  always_comb begin
    unique case (strobe.lowSel)
      LOW_RESULT: lowNext = coreResult;
      LOW_ZERO:   lowNext = '0;
      default:    lowNext = destIn[LANE_W-1:0];
    endcase
    destNext = '0;
    destNext[REG_W-1:LANE_W] = destIn[REG_W-1:LANE_W];
    destNext[LANE_W-1:0] = lowNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      destOut  <= '0;
      flagsOut <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        destOut  <= destNext;
        flagsOut <= strobe.flagEn ? coreFlags : '0;
      end
    end
  end
endmodule

// File: rtl/fms_lane_stage.sv
module fms_lane_stage
  import fms_pkg::*;
#(
  parameter int MAXVL = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        formSel,
  input  logic              negate,
  input  logic              maskOn,
  input  logic              maskBit,
  input  logic              zeroMode,
  input  logic              embRoundEn,
  input  logic [RM_W-1:0]   embRound,
  input  logic [RM_W-1:0]   ctlRound,
  input  logic              src3IsReg,
  input  logic [REG_W-1:0]  destIn,
  input  logic [REG_W-1:0]  src2In,
  input  logic [REG_W-1:0]  src3In,
  output logic [LANE_W-1:0] coreA,
  output logic [LANE_W-1:0] coreB,
  output logic [LANE_W-1:0] coreC,
  output logic              coreNeg,
  output logic [RM_W-1:0]   coreRound,
  input  logic [LANE_W-1:0] coreResult,
  input  logic [FLAG_W-1:0] coreFlags,
  output logic              outValid,
  output logic [MAXVL-1:0]  destOut,
  output logic [FLAG_W-1:0] flagsOut
);
  strobeT strobe;

  initial begin
    if (MAXVL < REG_W) $error("MAXVL must be at least %0d", REG_W);
  end

  fms_ctrl uCtrl (
    .formSel(formSel), .maskOn(maskOn), .maskBit(maskBit), .zeroMode(zeroMode),
    .embRoundEn(embRoundEn), .embRound(embRound), .ctlRound(ctlRound),
    .src3IsReg(src3IsReg), .strobe(strobe), .roundMode(coreRound)
  );

  fms_datapath #(.MAXVL(MAXVL)) uData (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strobe(strobe),
    .destIn(destIn), .src2In(src2In), .src3In(src3In),
    .coreA(coreA), .coreB(coreB), .coreC(coreC),
    .coreResult(coreResult), .coreFlags(coreFlags),
    .outValid(outValid), .destOut(destOut), .flagsOut(flagsOut)
  );

  assign coreNeg = negate;

  p_route_132_r1: assert property (@(posedge clk) disable iff (!rstN)
    formSel == 2'b00 |-> coreA == destIn[15:0] && coreB == src3In[15:0] && coreC == src2In[15:0]);
  p_route_213_r2: assert property (@(posedge clk) disable iff (!rstN)
    formSel == 2'b01 |-> coreA == src2In[15:0] && coreB == destIn[15:0] && coreC == src3In[15:0]);
  p_route_231_r3: assert property (@(posedge clk) disable iff (!rstN)
    formSel[1] |-> coreA == src2In[15:0] && coreB == src3In[15:0] && coreC == destIn[15:0]);
  p_round_emb_r5: assert property (@(posedge clk) disable iff (!rstN)
    embRoundEn && src3IsReg |-> coreRound == embRound);
  p_round_ctl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(embRoundEn && src3IsReg) |-> coreRound == ctlRound);
  p_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (!maskOn || maskBit) |=> destOut[LANE_W-1:0] == $past(coreResult));
  p_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid && maskOn && !maskBit && zeroMode |=> destOut[LANE_W-1:0] == '0);
  p_merge_r9: assert property (@(posedge clk) disable iff (!rstN)
    inValid && maskOn && !maskBit && !zeroMode |=> destOut[LANE_W-1:0] == $past(destIn[LANE_W-1:0]));
  p_upper_r10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> destOut[REG_W-1:LANE_W] == $past(destIn[REG_W-1:LANE_W]) && (destOut >> REG_W) == '0);
  p_flags_r11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> flagsOut == (($past(!maskOn || maskBit)) ? $past(coreFlags) : '0));
  p_valid_r12: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));
endmodule

// File: tb/fms_lane_stage_test.sv
module fms_lane_stage_test;
  localparam int CLK_PERIOD = 10;
  localparam int VL = 512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] formSel = '0;
  logic negate = 1'b0, maskOn = 1'b0, maskBit = 1'b0, zeroMode = 1'b0;
  logic embRoundEn = 1'b0, src3IsReg = 1'b0;
  logic [1:0] embRound = '0, ctlRound = '0;
  logic [127:0] destIn = '0, src2In = '0, src3In = '0;
  logic [15:0] coreA, coreB, coreC, coreResult;
  logic coreNeg, outValid;
  logic [1:0] coreRound;
  logic [4:0] coreFlags, flagsOut;
  logic [VL-1:0] destOut;

  int checks = 0;
  int errors = 0;
  bit doneFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] fakeRes(logic [15:0] a, b, c, logic n, logic [1:0] rm);
    return (a * 16'd3) ^ {b[14:0], b[15]} ^ ~c ^ {n, 13'd0, rm};
  endfunction
  function automatic logic [4:0] fakeFl(logic [15:0] a, b, c);
    return (a[4:0] ^ b[9:5] ^ c[14:10]) | 5'b00001;
  endfunction

  always_comb begin
    coreResult = fakeRes(coreA, coreB, coreC, coreNeg, coreRound);
    coreFlags  = fakeFl(coreA, coreB, coreC);
  end

  fms_lane_stage #(.MAXVL(VL)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .formSel(formSel), .negate(negate),
    .maskOn(maskOn), .maskBit(maskBit), .zeroMode(zeroMode), .embRoundEn(embRoundEn),
    .embRound(embRound), .ctlRound(ctlRound), .src3IsReg(src3IsReg),
    .destIn(destIn), .src2In(src2In), .src3In(src3In),
    .coreA(coreA), .coreB(coreB), .coreC(coreC), .coreNeg(coreNeg), .coreRound(coreRound),
    .coreResult(coreResult), .coreFlags(coreFlags),
    .outValid(outValid), .destOut(destOut), .flagsOut(flagsOut)
  );

  task automatic chk(bit ok, string tag, logic [VL-1:0] act, logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic runVec(int form, bit n, bit mOn, bit mBit, bit zr, bit eEn, bit s3r);
    logic [15:0] eA, eB, eC, expLow, expRes;
    logic [1:0] eRm;
    logic [VL-1:0] expDest;
    logic [4:0] expFl;
    string routeTag, lowTag;
    @(negedge clk);
    destIn = rnd128(); src2In = rnd128(); src3In = rnd128();
    formSel = form[1:0]; negate = n; maskOn = mOn; maskBit = mBit; zeroMode = zr;
    embRoundEn = eEn; src3IsReg = s3r;
    embRound = 2'($urandom()); ctlRound = ~embRound;
    inValid = 1'b1;
    case (form)
      0: begin eA = destIn[15:0]; eB = src3In[15:0]; eC = src2In[15:0]; routeTag = "R1"; end
      1: begin eA = src2In[15:0]; eB = destIn[15:0]; eC = src3In[15:0]; routeTag = "R2"; end
      default: begin eA = src2In[15:0]; eB = src3In[15:0]; eC = destIn[15:0]; routeTag = "R3"; end
    endcase
    eRm = (eEn && s3r) ? embRound : ctlRound;
    expRes = fakeRes(eA, eB, eC, n, eRm);
    if (!mOn || mBit) begin expLow = expRes; lowTag = "R7"; expFl = fakeFl(eA, eB, eC); end
    else if (zr) begin expLow = '0; lowTag = "R8"; expFl = '0; end
    else begin expLow = destIn[15:0]; lowTag = "R9"; expFl = '0; end
    expDest = '0;
    expDest[127:0] = {destIn[127:16], expLow};
    #1;
    chk({coreA, coreB, coreC} == {eA, eB, eC}, routeTag,
        VL'({coreA, coreB, coreC}), VL'({eA, eB, eC}));
    chk(coreNeg == n, "R4", VL'(coreNeg), VL'(n));
    chk(coreRound == eRm, (eEn && s3r) ? "R5" : "R6", VL'(coreRound), VL'(eRm));
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid == 1'b1, "R12", VL'(outValid), VL'(1));
    chk(destOut[15:0] == expLow, lowTag, VL'(destOut[15:0]), VL'(expLow));
    chk(destOut[VL-1:16] == expDest[VL-1:16], "R10", destOut, expDest);
    chk(flagsOut == expFl, "R11", VL'(flagsOut), VL'(expFl));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0 && destOut == '0 && flagsOut == '0, "R12 reset",
        destOut ^ VL'(outValid) ^ VL'(flagsOut), '0);
    rstN = 1'b1;
    for (int f = 0; f < 4; f++)
      for (int n = 0; n < 2; n++)
        for (int m = 0; m < 8; m++)
          for (int r = 0; r < 4; r++)
            runVec(f, n[0], m[2], m[1], m[0], r[1], r[0]);
    @(negedge clk);
    chk(outValid == 1'b0, "R12 idle", VL'(outValid), '0);
    doneFlag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule